// File: doc/BRIEF.md
# Three-Port Parallel I/O Unit (Basic Mode)

This block sits between a processor bus and three parallel ports: two 8-bit ports (A and B) and a third 8-bit port C that is handled as two independent 4-bit halves. The processor side has a chip select, read and write strobes, a two-bit register address and an 8-bit data bus. Writes are taken on the rising clock edge while chip select and write are both high. Read data is combinational while chip select and read are both high.

One register address accepts two kinds of control byte, and bit 7 tells them apart. With bit 7 set, the byte is a mode word. It sets the direction of each of the four port groups and clears every output latch. With bit 7 clear, the byte is an atomic command that sets or clears one port C bit and leaves the other seven alone. An output group drives its latched value onto its pins through a per-pin output enable. An input group returns the live pin levels, with no latching.

Top module: `ppio_basic`

## Requirements
- R1: Register address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A control read returns {1, 0, 0, dirA, dirCH, 0, dirB, dirCL}, where each dir bit is 1 for input.
- R2: After reset, every group is an input, so all output enables are 0. All output latches are 0, and a control read returns 8'h9B.
- R3: A control write with bit 7 = 1 sets the group directions: bit 4 for port A, bit 3 for the upper half of port C, bit 1 for port B and bit 0 for the lower half of port C, with 1 meaning input. The output enables of a group are all 1 when it is an output and all 0 when it is an input.
- R4: A mode word write clears every output latch (A, B and both halves of C) to zero.
- R5: A write to an output group stores the data in its latch, which drives the pins. A read of that group returns the latch contents.
- R6: A read of an input group returns the live pin value at the time of the read. A write to an input group is ignored.
- R7: A control write with bit 7 = 0 is a bit command. Bits 3..1 select the port C bit, bit 0 is its new value and bits 6..4 are ignored. Only the selected bit changes.
- R8: A bit command that targets a port C bit whose half is configured as input changes nothing.
- R9: Writes with chip select low have no effect. The read data is 0 unless chip select and read are both high.
- R10: Mode word 8'h91 makes port A an input, port B an output, the upper half of C an output and the lower half of C an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin output enable |

## Verification
A wrong direction bit shows up in the enables of the affected group right after the clock edge that takes the write. It also shows up as a wrong value in the control readback. A latch that is not cleared, or a bit command that touches a neighbouring bit, is visible on the pin outputs one cycle after the write. Reading from the pins instead of the latch, or the other way round, is exposed by driving pin levels that differ from the latch and reading in the same cycle.

// File: rtl/ppio_basic.sv
module ppio_basic #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         rd,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int H = W / 2;

  logic dir_a, dir_b, dir_ch, dir_cl;
  logic [W-1:0] lat_a, lat_b, lat_c;

  wire we      = cs & wr;
  wire ctl_we  = we & (addr == 2'd3);
  wire mode_we = ctl_we & wdata[7];
  wire bit_we  = ctl_we & ~wdata[7];
  wire [2:0] bit_idx = wdata[3:1];
  wire bit_in  = bit_idx[2] ? dir_ch : dir_cl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {dir_a, dir_b, dir_ch, dir_cl} <= 4'hF;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (mode_we) begin
      dir_a  <= wdata[4];
      dir_ch <= wdata[3];
      dir_b  <= wdata[1];
      dir_cl <= wdata[0];
      lat_a  <= '0;
      lat_b  <= '0;
      lat_c  <= '0;
    end else if (bit_we) begin
      if (!bit_in) lat_c[bit_idx] <= wdata[0];
    end else if (we) begin
      case (addr)
        2'd0: if (!dir_a) lat_a <= wdata;
        2'd1: if (!dir_b) lat_b <= wdata;
        2'd2: begin
          if (!dir_ch) lat_c[W-1:H] <= wdata[W-1:H];
          if (!dir_cl) lat_c[H-1:0] <= wdata[H-1:0];
        end
        default: ;
      endcase
    end
  end

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pa_oe  = {W{~dir_a}};
  assign pb_oe  = {W{~dir_b}};
  assign pc_oe  = {{H{~dir_ch}}, {H{~dir_cl}}};

  wire [W-1:0] view_a = dir_a ? pa_in : lat_a;
  wire [W-1:0] view_b = dir_b ? pb_in : lat_b;
  wire [W-1:0] view_c = {dir_ch ? pc_in[W-1:H] : lat_c[W-1:H],
                         dir_cl ? pc_in[H-1:0] : lat_c[H-1:0]};
  wire [W-1:0] view_k = {1'b1, 2'b00, dir_a, dir_ch, 1'b0, dir_b, dir_cl};

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      case (addr)
        2'd0:    rdata = view_a;
        2'd1:    rdata = view_b;
        2'd2:    rdata = view_c;
        default: rdata = view_k;
      endcase
    end
  end

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_we) |-> (pa_out == '0 && pb_out == '0 && pc_out == '0)); // R4
  AST_MODE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_we) |-> (pa_oe == {W{~$past(wdata[4])}} && pb_oe == {W{~$past(wdata[1])}})); // R3
  AST_BIT_ONLY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bit_we) |-> ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) && $stable(pb_out))); // R7
  AST_BIT_INPUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bit_we && bit_in) |-> $stable(pc_out)); // R8
  AST_NO_CS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs) |-> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pc_oe))); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == '0); // R9
endmodule

// File: tb/ppio_basic_test.sv
`timescale 1ns/1ps
module ppio_basic_test;
  logic clk = 0, rst_n = 0, cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  ppio_basic uut (.clk, .rst_n, .cs, .rd, .wr, .addr, .wdata, .rdata,
    .pa_in, .pa_out, .pa_oe, .pb_in, .pb_out, .pb_oe, .pc_in, .pc_out, .pc_oe);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d, logic sel = 1);
    @(negedge clk); cs = sel; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(string req, logic [1:0] a, logic [7:0] exp);
    @(negedge clk); cs = 1; rd = 1; addr = a; #1;
    chk(req, rdata, exp);
    cs = 0; rd = 0; #1;
    chk("R9 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_reset;
    chk("R2 pa_oe", pa_oe, 0); chk("R2 pb_oe", pb_oe, 0); chk("R2 pc_oe", pc_oe, 0);
    chk("R2 pa_out", pa_out, 0); chk("R2 pc_out", pc_out, 0);
    bus_rd("R2 ctl", 2'd3, 8'h9B);
  endtask

  task automatic t_inputs;
    pa_in = 8'h5A; bus_rd("R6 A live", 2'd0, 8'h5A);
    pa_in = 8'h77; bus_rd("R6 A changed", 2'd0, 8'h77);
    pc_in = 8'hC3; bus_rd("R1 C read", 2'd2, 8'hC3);
    bus_wr(2'd0, 8'hEE);
    chk("R6 write to input ignored", pa_out, 8'h00);
  endtask

  task automatic t_mode91;
    bus_wr(2'd3, 8'h91);
    chk("R10 pa_oe", pa_oe, 8'h00); chk("R10 pb_oe", pb_oe, 8'hFF);
    chk("R10 pc_oe", pc_oe, 8'hF0);
    bus_rd("R1 R3 ctl 91", 2'd3, 8'h91);
  endtask

  task automatic t_outputs;
    pb_in = 8'h11; pc_in = 8'h96;
    bus_wr(2'd1, 8'hA5);
    chk("R5 pb_out", pb_out, 8'hA5);
    bus_rd("R5 B read latch", 2'd1, 8'hA5);
    bus_wr(2'd2, 8'h3C);
    chk("R5 pc_out upper only", pc_out, 8'h30);
    bus_rd("R5 R6 C mixed", 2'd2, 8'h36);
  endtask

  task automatic t_bits;
    bus_wr(2'd3, 8'h7F);
    chk("R7 set PC7 ignore 6..4", pc_out, 8'hB0);
    bus_wr(2'd3, 8'h0A);
    chk("R7 clear PC5", pc_out, 8'h90);
    bus_wr(2'd3, 8'h03);
    chk("R8 PC1 input untouched", pc_out, 8'h90);
    pc_in = 8'h0F; bus_rd("R8 C lower pins", 2'd2, 8'h9F);
  endtask

  task automatic t_cs_and_clear;
    bus_wr(2'd3, 8'h80, 0);
    bus_rd("R9 cs low ignored", 2'd3, 8'h91);
    chk("R9 pb kept", pb_out, 8'hA5);
    bus_wr(2'd3, 8'h80);
    chk("R4 pb cleared", pb_out, 0); chk("R4 pc cleared", pc_out, 0);
    chk("R3 all out pa_oe", pa_oe, 8'hFF); chk("R3 all out pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h3E); bus_wr(2'd3, 8'h01);
    chk("R7 set PC0", pc_out, 8'h01);
    bus_wr(2'd3, 8'h8A);
    chk("R3 B in CH in", {pb_oe[0], pc_oe[7], pa_oe[0], pc_oe[0]}, 8'h03);
    chk("R4 A cleared", pa_out, 0); chk("R4 C cleared", pc_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_inputs; t_mode91; t_outputs; t_bits; t_cs_and_clear;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule